// File: doc/BRIEF.md
# Descriptor Ring Source Engine

This block is the sending half of a copy engine. Software places descriptors into a ring held in ordinary memory and then moves a write index forward through a small register port. Whenever the engine's own read index trails the write index, the engine fetches the next descriptor through a single memory read port. It then reads the referenced buffer one byte at a time and presents the bytes on a ready/valid byte stream. Each byte carries the descriptor's metadata tag and swap flag.

A descriptor can carry a gather mark, which joins it to the descriptor after it. The whole chain then leaves the block as one transfer, with a single end marker and a single completion pulse. After every descriptor the engine moves its read index forward, and software can read that index back. Software also sees a ring-full flag, high and low fill-level flags, and a sticky error bit that records any descriptor cut down to the configured maximum length.

Top module: `dre_src_engine`

## Requirements
- R1: After reset the read index reads 0, `out_valid`, `mem_rd_en` and `copy_done` are low, the ring is disabled (size 0), the low fill flag is high and the high fill flag and ring-full flag are low.
- R2: Descriptor n occupies two 32-bit words at byte address base + 8·n. The first word is the buffer byte address. The second word holds the byte count in bits [15:0] and the flags in bits [31:16]. In the flags, bit 0 is gather, bit 1 is byte swap and bits 15:2 are the 14-bit metadata tag.
- R3: The engine works through entries from its read index up to the write index, but not including it. It advances the read index by one after each descriptor and reports it at register 3. Registers: 0 base, 1 size, 2 write index, 3 read index, 4 maximum length, 5 fill marks (high in [31:16], low in [15:0]), 6 status (bit 0 error, bit 1 high flag, bit 2 low flag, bit 3 full).
- R4: Indices wrap by masking with size − 1, where the size is a power of two.
- R5: Byte k of a descriptor comes from byte address a + k, where a is the buffer address. Lane 0 of a memory word is its least significant byte. When the swap flag is set, the lane is inverted (lane XOR 3).
- R6: `out_meta` and `out_swap` carry the current descriptor's tag and swap flag. `out_last` marks the final byte of a descriptor whose gather bit is clear.
- R7: A chain of gather-marked descriptors, closed by one descriptor without the gather mark, produces exactly one `out_last` and one `copy_done`.
- R8: `copy_done` is a single-cycle pulse, raised once when each non-gather descriptor retires.
- R9: A byte count above the maximum length is cut to the maximum length, and the sticky error bit is set. Writing 1 to status bit 0 clears the error bit.
- R10: While the size register is 0, the engine issues no memory reads and the read index does not move, whatever the write index holds.
- R11: `ring_full` is high exactly when (write index + 1) masked equals the read index, so one entry always stays unused.
- R12: With pending = (write − read) masked, `wm_high` is high when pending ≥ the high mark, and `wm_low` is high when pending ≤ the low mark.
- R13: At most one memory read is outstanding at any time. `mem_rd_en` is never raised again before `mem_rd_valid` has returned.
- R14: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_last`, `out_meta` and `out_swap` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Word-aligned memory byte address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts byte |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a transfer |
| out_meta | output | 14 | Metadata tag of the current descriptor |
| out_swap | output | 1 | Swap flag of the current descriptor |
| copy_done | output | 1 | Transfer-complete pulse |
| ring_full | output | 1 | Ring has one free entry left |
| wm_high | output | 1 | Pending count at or above the high mark |
| wm_low | output | 1 | Pending count at or below the low mark |
| len_err | output | 1 | Sticky truncation error |

## Verification
The hardest state to reach from the ports is a ring that holds several pending entries at once. Left to itself, the engine drains each descriptor soon after the write index moves, so the full flag and the high fill flag show only briefly. The stimulus therefore holds `out_ready` low, which pins the engine on the first byte of the oldest descriptor. It then posts enough entries to fill all but one slot and reads the flags and status register while nothing can drain. Finally it releases the sink and checks the flags again once the ring is empty. A gather chain that crosses the ring's wrap point, and bytes taken from unaligned, swapped buffers while the sink stalls at random, make up the other difficult corners.

// File: rtl/dre_pkg.sv
package dre_pkg;

   localparam int WORD_W     = 32;
   localparam int LEN_W      = 16;
   localparam int FLAG_W     = 16;
   localparam int META_W     = 14;
   localparam int FLG_GATHER = 0;
   localparam int FLG_SWAP   = 1;
   localparam int META_LSB   = 2;
   localparam int DESC_SHIFT = 3;   // 8 bytes per descriptor
   localparam int REG_AW     = 3;

   localparam logic [REG_AW-1:0] RA_BASE  = 3'd0;
   localparam logic [REG_AW-1:0] RA_SIZE  = 3'd1;
   localparam logic [REG_AW-1:0] RA_WRIDX = 3'd2;
   localparam logic [REG_AW-1:0] RA_RDIDX = 3'd3;
   localparam logic [REG_AW-1:0] RA_MAXL  = 3'd4;
   localparam logic [REG_AW-1:0] RA_MARKS = 3'd5;
   localparam logic [REG_AW-1:0] RA_STAT  = 3'd6;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HDR_REQ,
      S_HDR_WAIT,
      S_CTL_REQ,
      S_CTL_WAIT,
      S_BYTE_REQ,
      S_BYTE_WAIT,
      S_BYTE_OUT,
      S_RETIRE
   } eng_state_e;

endpackage

// File: rtl/dre_lane.sv
module dre_lane #(
   parameter bit SWAP_EN = 1'b1
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  lane_i,
   input  logic        swap_i,
   output logic [7:0]  byte_o
);
   logic [1:0] sel;

   generate
      if (SWAP_EN) begin : g_swap
         assign sel = lane_i ^ {2{swap_i}};
      end else begin : g_plain
         logic unused_swap;
         assign unused_swap = swap_i;
         assign sel = lane_i;
      end
   endgenerate

   always_comb begin
      byte_o = word_i[8*sel +: 8];
   end
endmodule

// File: rtl/dre_regs.sv
module dre_regs
   import dre_pkg::*;
#(
   parameter int          IDX_W    = 4,
   parameter logic [15:0] MAXL_RST = 16'hFFFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [REG_AW-1:0]   addr_i,
   input  logic [WORD_W-1:0]   wdata_i,
   output logic [WORD_W-1:0]   rdata_o,
   input  logic [IDX_W-1:0]    rd_idx_i,
   input  logic                err_set_i,
   output logic [WORD_W-1:0]   base_o,
   output logic [IDX_W-1:0]    mask_o,
   output logic [IDX_W-1:0]    wr_idx_o,
   output logic [LEN_W-1:0]    max_len_o,
   output logic                ring_on_o,
   output logic                full_o,
   output logic                wm_high_o,
   output logic                wm_low_o,
   output logic                err_o
);
   localparam int SZW = IDX_W + 1;
   localparam logic [SZW-1:0] HI_RST = SZW'(1) << IDX_W;

   logic [WORD_W-1:0] base_q;
   logic [SZW-1:0]    size_q, hi_q, lo_q;
   logic [IDX_W-1:0]  wr_q;
   logic [LEN_W-1:0]  maxl_q;
   logic              err_q;
   logic [IDX_W-1:0]  pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         wr_q   <= '0;
         maxl_q <= MAXL_RST;
         hi_q   <= HI_RST;
         lo_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         if (wr_en_i) begin
            case (addr_i)
               RA_BASE:  base_q <= wdata_i;
               RA_SIZE:  size_q <= wdata_i[SZW-1:0];
               RA_WRIDX: wr_q   <= wdata_i[IDX_W-1:0];
               RA_MAXL:  maxl_q <= wdata_i[LEN_W-1:0];
               RA_MARKS: begin
                  hi_q <= wdata_i[16 +: SZW];
                  lo_q <= wdata_i[0 +: SZW];
               end
               default: ;
            endcase
         end
         if (err_set_i)
            err_q <= 1'b1;
         else if (wr_en_i && addr_i == RA_STAT && wdata_i[0])
            err_q <= 1'b0;
      end
   end

   assign mask_o    = IDX_W'(size_q - 1'b1);
   assign base_o    = base_q;
   assign wr_idx_o  = wr_q;
   assign max_len_o = maxl_q;
   assign ring_on_o = (size_q != '0);
   assign err_o     = err_q;
   assign pend      = (wr_q - rd_idx_i) & mask_o;
   assign full_o    = ring_on_o && (((wr_q + 1'b1) & mask_o) == rd_idx_i);
   assign wm_high_o = {1'b0, pend} >= hi_q;
   assign wm_low_o  = {1'b0, pend} <= lo_q;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         RA_BASE:  rdata_o = base_q;
         RA_SIZE:  rdata_o = WORD_W'(size_q);
         RA_WRIDX: rdata_o = WORD_W'(wr_q);
         RA_RDIDX: rdata_o = WORD_W'(rd_idx_i);
         RA_MAXL:  rdata_o = WORD_W'(maxl_q);
         RA_MARKS: rdata_o = (WORD_W'(hi_q) << 16) | WORD_W'(lo_q);
         RA_STAT:  rdata_o = {28'd0, full_o, wm_low_o, wm_high_o, err_q};
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/dre_engine.sv
module dre_engine
   import dre_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ring_on_i,
   input  logic [WORD_W-1:0]  base_i,
   input  logic [IDX_W-1:0]   mask_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [LEN_W-1:0]   max_len_i,
   output logic [IDX_W-1:0]   rd_idx_o,
   output logic               busy_o,
   output logic               err_set_o,
   output logic               mem_rd_en_o,
   output logic [WORD_W-1:0]  mem_rd_addr_o,
   input  logic               mem_rd_valid_i,
   input  logic [WORD_W-1:0]  mem_rd_data_i,
   output logic               out_valid_o,
   input  logic               out_ready_i,
   output logic [7:0]         out_byte_o,
   output logic               out_last_o,
   output logic [META_W-1:0]  out_meta_o,
   output logic               out_swap_o,
   output logic               copy_done_o
);
   eng_state_e        st_q, st_d;
   logic [IDX_W-1:0]  rd_q;
   logic [WORD_W-1:0] buf_q;
   logic [LEN_W-1:0]  len_q, cnt_q;
   logic [META_W-1:0] meta_q;
   logic              swap_q, gather_q;
   logic [7:0]        byte_q;

   logic [WORD_W-1:0] cur_addr, desc_addr;
   logic [7:0]        lane_byte;
   logic [LEN_W-1:0]  hdr_len, eff_len;
   logic [FLAG_W-1:0] hdr_flags;
   logic              too_long, last_byte;

   assign cur_addr  = buf_q + WORD_W'(cnt_q);
   assign desc_addr = base_i + (WORD_W'(rd_q) << DESC_SHIFT);
   assign hdr_len   = mem_rd_data_i[LEN_W-1:0];
   assign hdr_flags = mem_rd_data_i[WORD_W-1:LEN_W];
   assign too_long  = hdr_len > max_len_i;
   assign eff_len   = too_long ? max_len_i : hdr_len;
   assign last_byte = (cnt_q == len_q - 1'b1);

   dre_lane #(.SWAP_EN(SWAP_EN)) u_lane (
      .word_i (mem_rd_data_i),
      .lane_i (cur_addr[1:0]),
      .swap_i (swap_q),
      .byte_o (lane_byte)
   );

   always_comb begin
      st_d          = st_q;
      mem_rd_en_o   = 1'b0;
      mem_rd_addr_o = desc_addr;
      case (st_q)
         S_IDLE:
            if (ring_on_i && rd_q != (wr_idx_i & mask_i)) st_d = S_HDR_REQ;
         S_HDR_REQ: begin
            mem_rd_en_o = 1'b1;
            st_d        = S_HDR_WAIT;
         end
         S_HDR_WAIT:
            if (mem_rd_valid_i) st_d = S_CTL_REQ;
         S_CTL_REQ: begin
            mem_rd_en_o   = 1'b1;
            mem_rd_addr_o = desc_addr + WORD_W'(4);
            st_d          = S_CTL_WAIT;
         end
         S_CTL_WAIT:
            if (mem_rd_valid_i) st_d = (eff_len == '0) ? S_RETIRE : S_BYTE_REQ;
         S_BYTE_REQ: begin
            mem_rd_en_o   = 1'b1;
            mem_rd_addr_o = {cur_addr[WORD_W-1:2], 2'b00};
            st_d          = S_BYTE_WAIT;
         end
         S_BYTE_WAIT:
            if (mem_rd_valid_i) st_d = S_BYTE_OUT;
         S_BYTE_OUT:
            if (out_ready_i) st_d = last_byte ? S_RETIRE : S_BYTE_REQ;
         S_RETIRE:
            st_d = S_IDLE;
         default:
            st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         rd_q     <= '0;
         buf_q    <= '0;
         len_q    <= '0;
         cnt_q    <= '0;
         meta_q   <= '0;
         swap_q   <= 1'b0;
         gather_q <= 1'b0;
         byte_q   <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            S_HDR_WAIT:
               if (mem_rd_valid_i) buf_q <= mem_rd_data_i;
            S_CTL_WAIT:
               if (mem_rd_valid_i) begin
                  len_q    <= eff_len;
                  cnt_q    <= '0;
                  meta_q   <= hdr_flags[META_LSB +: META_W];
                  swap_q   <= hdr_flags[FLG_SWAP];
                  gather_q <= hdr_flags[FLG_GATHER];
               end
            S_BYTE_WAIT:
               if (mem_rd_valid_i) byte_q <= lane_byte;
            S_BYTE_OUT:
               if (out_ready_i && !last_byte) cnt_q <= cnt_q + 1'b1;
            S_RETIRE:
               rd_q <= (rd_q + 1'b1) & mask_i;
            default: ;
         endcase
      end
   end

   assign rd_idx_o    = rd_q;
   assign busy_o      = (st_q != S_IDLE);
   assign err_set_o   = (st_q == S_CTL_WAIT) && mem_rd_valid_i && too_long;
   assign out_valid_o = (st_q == S_BYTE_OUT);
   assign out_byte_o  = byte_q;
   assign out_last_o  = (st_q == S_BYTE_OUT) && last_byte && !gather_q;
   assign out_meta_o  = meta_q;
   assign out_swap_o  = swap_q;
   assign copy_done_o = (st_q == S_RETIRE) && !gather_q;
endmodule

// File: rtl/dre_src_engine.sv
module dre_src_engine
   import dre_pkg::*;
#(
   parameter int          IDX_W    = 4,
   parameter bit          SWAP_EN  = 1'b1,
   parameter logic [15:0] MAXL_RST = 16'hFFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               mem_rd_en,
   output logic [31:0]        mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [31:0]        mem_rd_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [7:0]         out_byte,
   output logic               out_last,
   output logic [13:0]        out_meta,
   output logic               out_swap,
   output logic               copy_done,
   output logic               ring_full,
   output logic               wm_high,
   output logic               wm_low,
   output logic               len_err
);
   generate
      if (IDX_W < 1 || IDX_W > 15) begin : g_bad_idx
         $error("dre_src_engine: IDX_W must lie in 1..15");
      end
   endgenerate

   logic [WORD_W-1:0] base_w;
   logic [IDX_W-1:0]  mask_w, wr_idx_w, rd_idx_w;
   logic [LEN_W-1:0]  max_len_w;
   logic              ring_on_w, busy_w, err_set_w;

   dre_regs #(.IDX_W(IDX_W), .MAXL_RST(MAXL_RST)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (reg_wr_en),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .rdata_o   (reg_rdata),
      .rd_idx_i  (rd_idx_w),
      .err_set_i (err_set_w),
      .base_o    (base_w),
      .mask_o    (mask_w),
      .wr_idx_o  (wr_idx_w),
      .max_len_o (max_len_w),
      .ring_on_o (ring_on_w),
      .full_o    (ring_full),
      .wm_high_o (wm_high),
      .wm_low_o  (wm_low),
      .err_o     (len_err)
   );

   dre_engine #(.IDX_W(IDX_W), .SWAP_EN(SWAP_EN)) u_eng (
      .clk            (clk),
      .rst_n          (rst_n),
      .ring_on_i      (ring_on_w),
      .base_i         (base_w),
      .mask_i         (mask_w),
      .wr_idx_i       (wr_idx_w),
      .max_len_i      (max_len_w),
      .rd_idx_o       (rd_idx_w),
      .busy_o         (busy_w),
      .err_set_o      (err_set_w),
      .mem_rd_en_o    (mem_rd_en),
      .mem_rd_addr_o  (mem_rd_addr),
      .mem_rd_valid_i (mem_rd_valid),
      .mem_rd_data_i  (mem_rd_data),
      .out_valid_o    (out_valid),
      .out_ready_i    (out_ready),
      .out_byte_o     (out_byte),
      .out_last_o     (out_last),
      .out_meta_o     (out_meta),
      .out_swap_o     (out_swap),
      .copy_done_o    (copy_done)
   );
endmodule

// File: rtl/dre_src_engine_chk.sv
module dre_src_engine_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_rd_en,
   input logic             mem_rd_valid,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_byte,
   input logic             out_last,
   input logic [13:0]      out_meta,
   input logic             out_swap,
   input logic             copy_done,
   input logic [IDX_W-1:0] rd_idx,
   input logic [IDX_W-1:0] mask,
   input logic             ring_on,
   input logic             busy
);
   // R13: a request is followed by a cycle without a new request
   a_r13_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R14: stalled output holds
   a_r14_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_byte) && $stable(out_last)
          && $stable(out_meta) && $stable(out_swap)));

   // R8: completion is one cycle wide
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> !copy_done);

   // R3 / R4: the read index only steps by one, wrapping under the mask
   a_r3_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx != $past(rd_idx)) |->
         (rd_idx == IDX_W'(($past(rd_idx) + 1'b1) & $past(mask))));

   // R10: a disabled, idle ring starts no reads
   a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_on && !busy) |=> !mem_rd_en);

   // R7: an end marker is only seen on a presented byte
   a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   logic unused_valid;
   assign unused_valid = mem_rd_valid;
endmodule

bind dre_src_engine dre_src_engine_chk #(.IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_rd_en    (mem_rd_en),
   .mem_rd_valid (mem_rd_valid),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_byte     (out_byte),
   .out_last     (out_last),
   .out_meta     (out_meta),
   .out_swap     (out_swap),
   .copy_done    (copy_done),
   .rd_idx       (rd_idx_w),
   .mask         (mask_w),
   .ring_on      (ring_on_w),
   .busy         (busy_w)
);

// File: tb/dre_src_engine_tb.sv
module dre_src_engine_tb;
   localparam int IW = 4;
   localparam logic [31:0] RBASE = 32'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_byte;
   logic        out_last;
   logic [13:0] out_meta;
   logic        out_swap;
   logic        copy_done, ring_full, wm_high, wm_low, len_err;

   always #4 clk = ~clk;

   dre_src_engine #(.IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last),
      .out_meta(out_meta), .out_swap(out_swap), .copy_done(copy_done),
      .ring_full(ring_full), .wm_high(wm_high), .wm_low(wm_low), .len_err(len_err)
   );

   logic [31:0] mem [0:255];
   always @(posedge clk) begin
      mem_rd_valid <= mem_rd_en;
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
   end

   typedef struct packed {
      logic [7:0]  b;
      logic        l;
      logic [13:0] m;
      logic        s;
   } exp_t;
   exp_t exp_q[$];

   int n_cmp = 0, n_bad = 0;
   int got_done = 0, exp_done = 0, rd_cnt = 0;
   int r13_viol = 0, r14_viol = 0;
   int maxlen_m = 64;
   int rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic void chk(input bit ok, input string req, input logic [31:0] act,
                               input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endfunction

   always @(posedge clk) begin
      #1;
      case (rdy_mode)
         0: out_ready = 1'b1;
         1: out_ready = lfsr[0] | lfsr[3];
         default: out_ready = 1'b0;
      endcase
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   end

   bit   pend_rd = 1'b0;
   bit   held = 1'b0;
   exp_t held_v;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) begin
            rd_cnt++;
            if (pend_rd) r13_viol++;
            pend_rd = 1'b1;
         end else if (mem_rd_valid) pend_rd = 1'b0;
         if (copy_done) got_done++;
         if (held && !(out_valid && {out_byte, out_last, out_meta, out_swap} == held_v))
            r14_viol++;
         held = out_valid && !out_ready;
         held_v = {out_byte, out_last, out_meta, out_swap};
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", {24'd0, out_byte}, 32'd0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(out_byte == e.b, "R5 byte", {24'd0, out_byte}, {24'd0, e.b});
               chk(out_last == e.l, "R6/R7 last", {31'd0, out_last}, {31'd0, e.l});
               chk(out_meta == e.m && out_swap == e.s, "R6 meta/swap",
                   {17'd0, out_meta, out_swap}, {17'd0, e.m, e.s});
            end
         end
      end
   end

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // Driver: writes a descriptor (R2) and pushes its expected bytes
   task automatic put_desc(input int idx, input logic [31:0] a, input int len,
                           input logic [13:0] meta, input bit gth, input bit swp);
      int eff;
      mem[(RBASE >> 2) + idx * 2]     = a;
      mem[(RBASE >> 2) + idx * 2 + 1] = {meta, swp, gth, 16'(len)};
      eff = (len > maxlen_m) ? maxlen_m : len;
      for (int k = 0; k < eff; k++) begin
         logic [31:0] ba;
         logic [1:0]  lane;
         exp_t e;
         ba   = a + 32'(k);
         lane = ba[1:0] ^ (swp ? 2'b11 : 2'b00);
         e.b  = mem[ba[9:2]][8*lane +: 8];
         e.l  = !gth && (k == eff - 1);
         e.m  = meta;
         e.s  = swp;
         exp_q.push_back(e);
      end
      if (!gth) exp_done++;
   endtask

   task automatic drain(input int exp_rd, input string req);
      logic [31:0] v;
      bit ok = 1'b0;
      for (int c = 0; c < 3000 && !ok; c++) begin
         reg_rd(3'd3, v);
         ok = (v[IW-1:0] == IW'(exp_rd)) && exp_q.size() == 0;
      end
      repeat (3) @(negedge clk);
      reg_rd(3'd3, v);
      chk(v == 32'(exp_rd), {req, " read index"}, v, 32'(exp_rd));
      chk(exp_q.size() == 0, {req, " bytes delivered"}, 32'(exp_q.size()), 32'd0);
      chk(got_done == exp_done, {req, " R8 completions"}, 32'(got_done), 32'(exp_done));
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 256; i++) mem[i] = 32'hC3A50000 ^ (32'(i) * 32'h01030507);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!out_valid && !mem_rd_en && !copy_done, "R1 outputs idle",
          {29'd0, out_valid, mem_rd_en, copy_done}, 32'd0);
      reg_rd(3'd3, v);
      chk(v == 0, "R1 read index", v, 0);
      chk(wm_low && !wm_high && !ring_full, "R1 flags",
          {29'd0, wm_low, wm_high, ring_full}, 32'd4);

      // R10 disabled ring ignores the write index
      reg_wr(3'd2, 32'd1);
      repeat (20) @(negedge clk);
      chk(rd_cnt == 0, "R10 no memory reads", 32'(rd_cnt), 0);
      reg_rd(3'd3, v);
      chk(v == 0, "R10 read index unchanged", v, 0);
      reg_wr(3'd2, 32'd0);

      reg_wr(3'd0, RBASE);
      reg_wr(3'd4, 32'd64);
      reg_wr(3'd1, 32'd4);

      // R2 R3 R5 R6 R8 plain descriptor
      put_desc(0, 32'h200, 5, 14'd3, 1'b0, 1'b0);
      reg_wr(3'd2, 32'd1);
      drain(1, "R3 single");

      // R5 swap with unaligned start
      put_desc(1, 32'h211, 6, 14'h2A, 1'b0, 1'b1);
      reg_wr(3'd2, 32'd2);
      drain(2, "R5 swapped");

      // R7 gather chain crossing the wrap point (R4)
      put_desc(2, 32'h240, 3, 14'd5, 1'b1, 1'b0);
      put_desc(3, 32'h250, 2, 14'd6, 1'b1, 1'b1);
      put_desc(0, 32'h262, 4, 14'd7, 1'b0, 1'b0);
      reg_wr(3'd2, 32'd1);
      drain(1, "R4/R7 gather wrap");

      // R9 truncation and error clear
      reg_wr(3'd4, 32'd4);
      maxlen_m = 4;
      put_desc(1, 32'h280, 9, 14'd9, 1'b0, 1'b0);
      reg_wr(3'd2, 32'd2);
      drain(2, "R9 truncate");
      chk(len_err == 1'b1, "R9 error set", {31'd0, len_err}, 1);
      reg_rd(3'd6, v);
      chk(v[0] == 1'b1, "R9 status bit", v, 1);
      reg_wr(3'd6, 32'd1);
      @(negedge clk);
      chk(len_err == 1'b0, "R9 error cleared", {31'd0, len_err}, 0);
      reg_wr(3'd4, 32'd64);
      maxlen_m = 64;

      // R14 random backpressure
      rdy_mode = 1;
      put_desc(2, 32'h2A1, 7, 14'h11, 1'b0, 1'b1);
      put_desc(3, 32'h2C0, 5, 14'h12, 1'b0, 1'b0);
      reg_wr(3'd2, 32'd0);
      drain(0, "R14 backpressure");
      rdy_mode = 0;

      // R11 R12 stalled ring with three pending entries
      reg_wr(3'd5, {16'd3, 16'd1});
      rdy_mode = 2;
      put_desc(0, 32'h300, 2, 14'd1, 1'b0, 1'b0);
      put_desc(1, 32'h310, 2, 14'd2, 1'b0, 1'b0);
      put_desc(2, 32'h320, 2, 14'd3, 1'b0, 1'b0);
      reg_wr(3'd2, 32'd3);
      repeat (20) @(negedge clk);
      chk(ring_full == 1'b1, "R11 full with one slot left", {31'd0, ring_full}, 1);
      chk(wm_high && !wm_low, "R12 high mark reached", {30'd0, wm_high, wm_low}, 2);
      reg_rd(3'd6, v);
      chk(v[3:1] == 3'b101, "R11/R12 status bits", {29'd0, v[3:1]}, 5);
      rdy_mode = 0;
      drain(3, "R12 drain");
      chk(!ring_full && !wm_high && wm_low, "R11/R12 empty flags",
          {29'd0, ring_full, wm_high, wm_low}, 1);

      chk(r13_viol == 0, "R13 single outstanding read", 32'(r13_viol), 0);
      chk(r14_viol == 0, "R14 stall hold", 32'(r14_viol), 0);

      summary();
      $finish;
   end
endmodule